// File: doc/BRIEF.md
# Quadrature Position Counter

This block turns the two raw phase signals of an incremental encoder into a signed position count. Each phase input is resynchronised to the block clock and then passed through a deglitch stage. The stage passes a new level only once the input has held that level for a programmable time, set in 100 ns units. The cleaned phases feed a decoder. A two-bit mode field picks the edge multiplier and selects either direction-aware counting or forward-only counting. A separate bit inverts phase A at the pin, which reverses the sign of counting.

An external strobe pin is synchronised and edge-detected. Each rising edge copies the live position into a registration register and sets a sticky valid flag. All configuration inputs are static: they are changed only while reset is asserted. After reset the filtered phase levels start at 0, so the bench and the system hold the inverted-A and B pins low when reset is released.

Top module: `quad_position_counter`

## Requirements
- R1: With setting S on `cfg_filt`, a phase level reaches the decoder only after it has held for N = S × STEP_CYC consecutive synchronised samples (N = 1 when S is 0). A pulse of N−1 samples is discarded and causes no count. A pulse of N samples is accepted.
- R2: Mode 00 changes the count by one on each edge of A. The count goes up when the new A level differs from B and goes down otherwise. Edges of B alone do not count. One full cycle gives ±2.
- R3: Mode 01 changes the count by one on every edge of A or B. An edge of A counts up when the new A differs from B. An edge of B counts up when the new B equals A. One full cycle gives ±4.
- R4: Mode 10 adds one for each rising edge of A and ignores B. One full cycle gives +1 in either rotation direction.
- R5: Mode 11 adds one for each edge of A and ignores B. One full cycle gives +2 in either rotation direction. The count never decreases.
- R6: With `cfg_inv_a` high, phase A is inverted before synchronisation. This reverses the sign of counting in modes 00 and 01.
- R7: In mode 01, a sample in which both filtered phases change together leaves the count unchanged.
- R8: The position is POS_W bits wide in two's complement and wraps on overflow and on underflow.
- R9: Each rising edge of `strobe` copies the position into `latched_pos` exactly once, however long the strobe stays high. The same edge sets `latch_valid`, which stays set until reset.
- R10: When the strobe capture and a count step fall in the same clock cycle, `latched_pos` receives the value from before that step.
- R11: After reset, `position`, `latched_pos` and `latch_valid` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a | input | 1 | Raw encoder phase A |
| enc_b | input | 1 | Raw encoder phase B |
| strobe | input | 1 | Registration strobe, rising edge captures |
| cfg_filt | input | 4 | Stability time in 100 ns units |
| cfg_mode | input | 2 | 00 2x dir, 01 4x dir, 10 1x fwd, 11 2x fwd |
| cfg_inv_a | input | 1 | Invert phase A |
| position | output | POS_W | Live position, two's complement |
| latched_pos | output | POS_W | Position captured on the last strobe |
| latch_valid | output | 1 | Set by the first capture since reset |

## Verification
A strobe capture and a count step can land on the same clock edge. The capture must then see the old count, not the new one. The bench provokes this with the filter set to zero in mode 10. It raises A and then raises the strobe one cycle later, so both paths reach their registers on the same edge. A repeat with the strobe two cycles behind A must capture the stepped value. Comparing the two results tells a pre-step capture apart from a post-step capture and from a missed capture.

// File: rtl/qpc_pkg.sv
package qpc_pkg;
  typedef enum logic [1:0] {
    QM_X2_DIR = 2'b00,
    QM_X4_DIR = 2'b01,
    QM_X1_FWD = 2'b10,
    QM_X2_FWD = 2'b11
  } qpc_mode_e;
endpackage

// File: rtl/qpc_input_filter.sv
module qpc_input_filter #(
  parameter int STEP_CYC = 25
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       raw,
  input  logic [3:0] setting,
  output logic       level
);
  localparam int LIM_MAX = 15 * STEP_CYC;
  localparam int LIM_W   = $clog2(LIM_MAX + 1) + 1;

  logic             sync1_q, sync2_q, level_q, level_d;
  logic [LIM_W-1:0] cnt_q, cnt_d, limit;

  assign limit = LIM_W'(setting) * LIM_W'(STEP_CYC);

  always_comb begin
    level_d = level_q;
    cnt_d   = '0;
    if (sync2_q != level_q) begin
      if ((limit == '0) || (cnt_q + 1'b1 >= limit)) begin
        level_d = sync2_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      level_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      sync1_q <= raw;
      sync2_q <= sync1_q;
      level_q <= level_d;
      cnt_q   <= cnt_d;
    end
  end

  assign level = level_q;
endmodule

// File: rtl/qpc_quad_decoder.sv
module qpc_quad_decoder
  import qpc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       a,
  input  logic       b,
  input  logic [1:0] mode,
  output logic       step,
  output logic       up
);
  logic a_q, b_q, a_chg, b_chg;

  assign a_chg = a ^ a_q;
  assign b_chg = b ^ b_q;

  always_comb begin
    step = 1'b0;
    up   = 1'b1;
    case (qpc_mode_e'(mode))
      QM_X2_DIR: begin
        step = a_chg;
        up   = a ^ b;
      end
      QM_X4_DIR: begin
        step = a_chg ^ b_chg;
        up   = a_chg ? (a ^ b) : ~(a ^ b);
      end
      QM_X1_FWD: begin
        step = a & ~a_q;
        up   = 1'b1;
      end
      default: begin
        step = a_chg;
        up   = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
    end else begin
      a_q <= a;
      b_q <= b;
    end
  end
endmodule

// File: rtl/qpc_pos_latch.sv
module qpc_pos_latch #(
  parameter int POS_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             up,
  input  logic             strobe,
  output logic [POS_W-1:0] position,
  output logic [POS_W-1:0] latched_pos,
  output logic             latch_valid
);
  logic [POS_W-1:0] pos_q, pos_d, reg_q, reg_d;
  logic             st1_q, st2_q, st3_q, valid_q, valid_d, capture;

  assign capture = st2_q & ~st3_q;

  always_comb begin
    pos_d = pos_q;
    if (step) begin
      pos_d = up ? pos_q + 1'b1 : pos_q - 1'b1;
    end
    reg_d   = capture ? pos_q : reg_q;
    valid_d = valid_q | capture;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q   <= '0;
      reg_q   <= '0;
      valid_q <= 1'b0;
      st1_q   <= 1'b0;
      st2_q   <= 1'b0;
      st3_q   <= 1'b0;
    end else begin
      pos_q   <= pos_d;
      reg_q   <= reg_d;
      valid_q <= valid_d;
      st1_q   <= strobe;
      st2_q   <= st1_q;
      st3_q   <= st2_q;
    end
  end

  assign position    = pos_q;
  assign latched_pos = reg_q;
  assign latch_valid = valid_q;
endmodule

// File: rtl/quad_position_counter.sv
module quad_position_counter #(
  parameter int POS_W    = 32,
  parameter int STEP_CYC = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enc_a,
  input  logic             enc_b,
  input  logic             strobe,
  input  logic [3:0]       cfg_filt,
  input  logic [1:0]       cfg_mode,
  input  logic             cfg_inv_a,
  output logic [POS_W-1:0] position,
  output logic [POS_W-1:0] latched_pos,
  output logic             latch_valid
);
  localparam int NCH = 2;

  logic           rst_s1_q, rst_s2_q, rst_int_n;
  logic [NCH-1:0] raw_ph, filt_ph;
  logic           filt_a, filt_b, step, up;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_int_n = rst_s2_q;

  assign raw_ph = {enc_b, enc_a ^ cfg_inv_a};

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ph
    qpc_input_filter #(.STEP_CYC(STEP_CYC)) u_filt (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .raw     (raw_ph[ch]),
      .setting (cfg_filt),
      .level   (filt_ph[ch])
    );
  end

  assign filt_a = filt_ph[0];
  assign filt_b = filt_ph[1];

  qpc_quad_decoder u_dec (
    .clk   (clk),
    .rst_n (rst_int_n),
    .a     (filt_a),
    .b     (filt_b),
    .mode  (cfg_mode),
    .step  (step),
    .up    (up)
  );

  qpc_pos_latch #(.POS_W(POS_W)) u_pos (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .step        (step),
    .up          (up),
    .strobe      (strobe),
    .position    (position),
    .latched_pos (latched_pos),
    .latch_valid (latch_valid)
  );
endmodule

// File: rtl/qpc_checker.sv
module qpc_checker #(
  parameter int POS_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       cfg_mode,
  input logic             filt_a,
  input logic             filt_b,
  input logic [POS_W-1:0] position,
  input logic [POS_W-1:0] latched_pos,
  input logic             latch_valid
);
  logic [POS_W-1:0] one_v;
  assign one_v = POS_W'(1);

  // R8
  step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (position == $past(position)) || (position - $past(position) == one_v) ||
    ($past(position) - position == one_v));

  // R5
  fwd_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mode[1] |-> (position == $past(position)) ||
                    (position - $past(position) == one_v));

  // R7
  illegal_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'b01 && filt_a != $past(filt_a) && filt_b != $past(filt_b))
      |=> position == $past(position));

  // R9
  valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(latch_valid));

  // R9
  capture_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (latched_pos != $past(latched_pos)) |-> (latched_pos == $past(position)) && latch_valid);
endmodule

bind quad_position_counter qpc_checker #(.POS_W(POS_W)) u_qpc_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_mode    (cfg_mode),
  .filt_a      (filt_a),
  .filt_b      (filt_b),
  .position    (position),
  .latched_pos (latched_pos),
  .latch_valid (latch_valid)
);

// File: tb/quad_position_counter_bench.sv
module quad_position_counter_bench;
  localparam int PW = 8;
  localparam int SC = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enc_a = 1'b0, enc_b = 1'b0, strobe = 1'b0;
  logic [3:0]    cfg_filt = 4'd1;
  logic [1:0]    cfg_mode = 2'b01;
  logic          cfg_inv_a = 1'b0;
  logic [PW-1:0] position, latched_pos;
  logic          latch_valid;

  int n_tests = 0, n_fail = 0, cyc = 0, ph = 0;
  bit finished = 0;

  quad_position_counter #(.POS_W(PW), .STEP_CYC(SC)) u_quad_position_counter (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .strobe(strobe),
    .cfg_filt(cfg_filt), .cfg_mode(cfg_mode), .cfg_inv_a(cfg_inv_a),
    .position(position), .latched_pos(latched_pos), .latch_valid(latch_valid));

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000 && !finished) begin
      finished = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: act=%0d cycles exp=<150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic check(string req, logic [PW-1:0] act, logic [PW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // physical phase sequence, A leading B: 00,10,11,01
  task automatic put_ph();
    enc_a = (ph == 1 || ph == 2);
    enc_b = (ph == 2 || ph == 3);
  endtask

  task automatic do_reset(logic [1:0] m, logic inv, logic [3:0] f);
    @(negedge clk);
    rst_n = 1'b0; strobe = 1'b0;
    cfg_mode = m; cfg_inv_a = inv; cfg_filt = f;
    ph = inv ? 1 : 0;
    put_ph();
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(4);
  endtask

  task automatic move(bit fwd, int edges, int hold);
    for (int i = 0; i < edges; i++) begin
      ph = fwd ? (ph + 1) % 4 : (ph + 3) % 4;
      put_ph();
      wait_cyc(hold);
    end
  endtask

  initial begin
    // R11 reset state
    do_reset(2'b01, 1'b0, 4'd1);
    check("R11 position", position, '0);
    check("R11 latched", latched_pos, '0);
    check("R11 valid", {7'd0, latch_valid}, 8'd0);

    // R1 filter sweep: mode 10 counts one per accepted A pulse
    for (int s = 0; s < 16; s++) begin
      int n;
      n = (s == 0) ? 1 : s * SC;
      do_reset(2'b10, 1'b0, 4'(s));
      if (n > 1) begin
        enc_a = 1'b1; wait_cyc(n - 1); enc_a = 1'b0; wait_cyc(n + 6);
        check($sformatf("R1 short pulse setting %0d", s), position, 8'd0);
      end
      enc_a = 1'b1; wait_cyc(n); enc_a = 1'b0; wait_cyc(n + 6);
      check($sformatf("R1 full pulse setting %0d", s), position, 8'd1);
    end

    // R2 R3 R4 R5 R6 mode x inversion x direction sweep, 3 full cycles
    for (int m = 0; m < 4; m++) begin
      for (int inv = 0; inv < 2; inv++) begin
        for (int fw = 0; fw < 2; fw++) begin
          int mult, sgn, exp;
          mult = (m == 0) ? 2 : (m == 1) ? 4 : (m == 2) ? 1 : 2;
          sgn  = (m >= 2) ? 1 : (((fw != 0) ^ (inv != 0)) ? 1 : -1);
          exp  = 3 * mult * sgn;
          do_reset(2'(m), 1'(inv), 4'd1);
          move(fw != 0, 12, 6);
          check($sformatf("R%0s mode %0d inv %0d fwd %0d",
                 (inv != 0 && m < 2) ? "6" : (m == 0) ? "2" : (m == 1) ? "3" :
                 (m == 2) ? "4" : "5", m, inv, fw), position, 8'(exp));
        end
      end
    end

    // R7 both phases change together in 4x
    do_reset(2'b01, 1'b0, 4'd1);
    enc_a = 1'b1; enc_b = 1'b1; wait_cyc(8);
    check("R7 00->11", position, 8'd0);
    enc_a = 1'b0; enc_b = 1'b0; wait_cyc(8);
    check("R7 11->00", position, 8'd0);
    enc_a = 1'b1; wait_cyc(8);
    check("R7 live after", position, 8'd1);

    // R8 wrap
    do_reset(2'b01, 1'b0, 4'd1);
    move(1'b0, 1, 6);
    check("R8 underflow", position, 8'hFF);
    move(1'b1, 1, 6);
    move(1'b1, 132, 6);
    check("R8 overflow", position, 8'h84);

    // R9 single capture per strobe edge
    do_reset(2'b01, 1'b0, 4'd1);
    move(1'b1, 5, 6);
    strobe = 1'b1; wait_cyc(6);
    check("R9 captured", latched_pos, 8'd5);
    check("R9 valid", {7'd0, latch_valid}, 8'd1);
    move(1'b1, 4, 6);
    check("R9 held strobe no recapture", latched_pos, 8'd5);
    strobe = 1'b0; wait_cyc(6);
    check("R9 strobe fall no capture", latched_pos, 8'd5);
    check("R9 valid sticky", {7'd0, latch_valid}, 8'd1);
    strobe = 1'b1; wait_cyc(6);
    check("R9 second capture", latched_pos, 8'd9);
    strobe = 1'b0;

    // R10 coincident capture and step
    do_reset(2'b10, 1'b0, 4'd0);
    enc_a = 1'b1; wait_cyc(1); strobe = 1'b1; wait_cyc(8);
    check("R10 same-edge capture", latched_pos, 8'd0);
    check("R10 position", position, 8'd1);
    strobe = 1'b0; enc_a = 1'b0; wait_cyc(8);
    enc_a = 1'b1; wait_cyc(2); strobe = 1'b1; wait_cyc(8);
    check("R10 later capture", latched_pos, 8'd2);
    strobe = 1'b0;

    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule